// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources, merges each with a software-raised pending bit, masks the result with an enable register and steers every source to one of two processor request lines: a normal request (`irq_o`) or a fast request (`fiq_o`). All configuration and status sit behind a simple 32-bit memory-mapped register port with a 12-bit byte address. A read returns its data one cycle later, flagged by `bus_rvalid`. A write takes effect at the clock edge where it is presented. The port applies no back-pressure, so a request is accepted on every cycle that `bus_en` is high.

Sixteen vector slots each name one source and hold a handler address. Slot 0 has the highest priority. Reading the current-vector register returns the handler address of the best slot whose source is active on the normal request line, or a default address if no slot matches. A read that finds a slot marks that slot's priority level as in service. This masks the slot and every lower-priority slot until software writes the current-vector register, which retires the highest-priority level in service. Higher-priority slots can still preempt, so nested handlers work.

Software-visible storage also includes a protection flag, a test-control flag and four read-only identification bytes.

Top module: `vector_irq_ctrl`

## Requirements
- R1: After reset the enable, route-select, soft-pending, protection, test-control, vector address, vector control and default address registers all read 0, `irq_o` and `fiq_o` are low, and no priority level is in service.
- R2: Offset 0x08 reads the raw pending word, which is the bitwise OR of `src_i` and the soft-pending register.
- R3: Writing ones to offset 0x10 sets those enable bits, and writing ones to offset 0x14 clears them. Zero bits in either write leave the enables unchanged. Offset 0x10 reads the enables back.
- R4: Writing ones to offset 0x18 sets soft-pending bits, and writing ones to offset 0x1c clears them. Offset 0x18 reads the bits back. A set soft bit makes its source pending exactly as a high `src_i` line does, and the bit stays set until it is cleared.
- R5: Offset 0x0c is the route-select register, where bit value 1 routes a source to the fast line and 0 routes it to the normal line. Offset 0x00 reads raw & enable & ~select, and offset 0x04 reads raw & enable & select.
- R6: `irq_o` is the OR of the offset-0x00 status and `fiq_o` is the OR of the offset-0x04 status. Each is registered, so it changes one clock edge after its inputs change.
- R7: Vector control for slot i is at 0x200+4*i, with bit 5 as the slot enable and bits 4:0 as the source number. The slot address is at 0x100+4*i. Reading offset 0x30 returns the address of the lowest-numbered enabled slot whose source is set in the offset-0x00 status and whose priority is above every level in service.
- R8: Offset 0x34 holds the default address. A read of 0x30 that finds no eligible slot returns it and changes no in-service state.
- R9: A read of 0x30 that returns slot k marks level k in service. A write of any value to 0x30 retires the highest-priority level in service, and does nothing if none is in service.
- R10: The protection flag at offset 0x20 and the test-control flag at offset 0x300 are plain read/write storage in bit 0.
- R11: Offsets 0xfe0, 0xfe4, 0xfe8 and 0xfec return bytes 0 to 3 of the identification word in bits 7:0, least significant byte first. Bits 19:12 of the assembled word carry the vendor code.
- R12: Every read sets `bus_rvalid` for one cycle after the request. Unmapped and write-only offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench drives nested vector reads in which a lower slot stays active while a higher slot arrives, and it retires levels one at a time. A design that retired the wrong level, or that masked only the exact slot instead of everything below it, would return the wrong address or the default at the wrong time. It also writes all-zero words to the set and clear registers, so a design that copied the word instead of treating it as write-one-to-act would lose its enables. Random streams of route changes, soft bits and source edges are checked against a bench model of the status words and the one-cycle lag of the request lines. A design that leaked a fast-routed source into the vector choice, or that drove the request lines combinationally, would disagree with that model.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_FIQ_STAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RAW      = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ROUTE    = 12'h00c;
  localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SW_SET   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_SW_CLR   = 12'h01c;
  localparam logic [ADDR_W-1:0] OFS_PROT     = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_VEC_CUR  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_VEC_DEF  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_TEST     = 12'h300;

  localparam logic [3:0] PAGE_VADDR = 4'h1;
  localparam logic [3:0] PAGE_VCTRL = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_ID_BASE = 12'hfe0;
endpackage

// File: rtl/vic_src_regs.sv
module vic_src_regs #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_route,
  input  logic            wr_en_set,
  input  logic            wr_en_clr,
  input  logic            wr_sw_set,
  input  logic            wr_sw_clr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] soft_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      soft_q  <= '0;
    end else begin
      if (wr_route)  route_q <= wdata;
      if (wr_en_set) en_q    <= en_q | wdata;
      if (wr_en_clr) en_q    <= en_q & ~wdata;
      if (wr_sw_set) soft_q  <= soft_q | wdata;
      if (wr_sw_clr) soft_q  <= soft_q & ~wdata;
    end
  end

  always_comb begin
    raw      = src_i | soft_q;
    irq_stat = raw & en_q & ~route_q;
    fiq_stat = raw & en_q & route_q;
  end
endmodule

// File: rtl/vic_vec_pri.sv
module vic_vec_pri #(
  parameter int NSRC   = 32,
  parameter int NSLOT  = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          irq_stat,
  input  logic [$clog2(NSLOT)-1:0] slot_idx,
  input  logic                     wr_vaddr,
  input  logic                     wr_vctrl,
  input  logic                     wr_def,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     rd_cur,
  input  logic                     wr_ack,
  output logic [DATA_W-1:0]        sel_vaddr,
  output logic [$clog2(NSRC):0]    sel_vctrl,
  output logic [DATA_W-1:0]        def_q,
  output logic [DATA_W-1:0]        cur_addr,
  output logic [NSLOT-1:0]         stack_q
);
  localparam int SRC_W  = $clog2(NSRC);
  localparam int CTRL_W = SRC_W + 1;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int LVL_W  = SLOT_W + 1;

  logic [DATA_W-1:0] vaddr_q [NSLOT];
  logic [CTRL_W-1:0] vctrl_q [NSLOT];
  logic [LVL_W-1:0]  lvl;
  logic              hit;
  logic [SLOT_W-1:0] win;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vaddr_q[g] <= '0;
        vctrl_q[g] <= '0;
      end else begin
        if (wr_vaddr && slot_idx == SLOT_W'(g)) vaddr_q[g] <= wdata;
        if (wr_vctrl && slot_idx == SLOT_W'(g)) vctrl_q[g] <= wdata[CTRL_W-1:0];
      end
    end
  end

  // highest-priority level currently in service (NSLOT when none)
  always_comb begin
    lvl = LVL_W'(NSLOT);
    for (int i = NSLOT - 1; i >= 0; i--)
      if (stack_q[i]) lvl = LVL_W'(i);
  end

  // lowest-numbered eligible slot above the in-service level
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (LVL_W'(i) < lvl && vctrl_q[i][SRC_W] &&
          irq_stat[vctrl_q[i][SRC_W-1:0]]) begin
        hit = 1'b1;
        win = SLOT_W'(i);
      end
    end
  end

  assign cur_addr  = hit ? vaddr_q[win] : def_q;
  assign sel_vaddr = vaddr_q[slot_idx];
  assign sel_vctrl = vctrl_q[slot_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      def_q   <= '0;
      stack_q <= '0;
    end else begin
      if (wr_def) def_q <= wdata;
      if (rd_cur && hit) stack_q[win] <= 1'b1;
      else if (wr_ack)   stack_q <= stack_q & (stack_q - 1'b1);
    end
  end
endmodule

// File: rtl/vic_req_out.sv
module vic_req_out #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_stat,
  input  logic [NSRC-1:0] fiq_stat,
  output logic            irq_o,
  output logic            fiq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_stat;
      fiq_o <= |fiq_stat;
    end
  end
endmodule

// File: rtl/vector_irq_ctrl.sv
module vector_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          NSRC    = 32,
  parameter int          NSLOT   = 16,
  parameter logic [31:0] ID_WORD = 32'h0004_1190
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int SRC_W  = $clog2(NSRC);
  localparam int SLOT_W = $clog2(NSLOT);

  logic wr, rd;
  logic [NSRC-1:0] en_q, route_q, soft_q, raw, irq_stat, fiq_stat;
  logic [NSLOT-1:0] stack_q;
  logic [31:0] sel_vaddr, def_q, cur_addr, rd_next;
  logic [SRC_W:0] sel_vctrl;
  logic prot_q, test_q;
  logic slot_ok, in_vaddr, in_vctrl;
  logic [SLOT_W-1:0] slot_idx;

  assign wr = bus_en & bus_wr;
  assign rd = bus_en & ~bus_wr;

  assign slot_idx = bus_addr[2 +: SLOT_W];
  assign slot_ok  = (bus_addr[1:0] == 2'b00) && (32'(bus_addr[7:2]) < NSLOT);
  assign in_vaddr = slot_ok && bus_addr[11:8] == PAGE_VADDR;
  assign in_vctrl = slot_ok && bus_addr[11:8] == PAGE_VCTRL;

  vic_src_regs #(.NSRC(NSRC)) u_src (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .wr_route (wr && bus_addr == OFS_ROUTE),
    .wr_en_set(wr && bus_addr == OFS_EN_SET),
    .wr_en_clr(wr && bus_addr == OFS_EN_CLR),
    .wr_sw_set(wr && bus_addr == OFS_SW_SET),
    .wr_sw_clr(wr && bus_addr == OFS_SW_CLR),
    .wdata(bus_wdata[NSRC-1:0]),
    .en_q(en_q), .route_q(route_q), .soft_q(soft_q),
    .raw(raw), .irq_stat(irq_stat), .fiq_stat(fiq_stat)
  );

  vic_vec_pri #(.NSRC(NSRC), .NSLOT(NSLOT), .DATA_W(32)) u_vec (
    .clk(clk), .rst_n(rst_n), .irq_stat(irq_stat), .slot_idx(slot_idx),
    .wr_vaddr(wr && in_vaddr),
    .wr_vctrl(wr && in_vctrl),
    .wr_def  (wr && bus_addr == OFS_VEC_DEF),
    .wdata(bus_wdata),
    .rd_cur(rd && bus_addr == OFS_VEC_CUR),
    .wr_ack(wr && bus_addr == OFS_VEC_CUR),
    .sel_vaddr(sel_vaddr), .sel_vctrl(sel_vctrl), .def_q(def_q),
    .cur_addr(cur_addr), .stack_q(stack_q)
  );

  vic_req_out #(.NSRC(NSRC)) u_out (
    .clk(clk), .rst_n(rst_n), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      test_q <= 1'b0;
    end else if (wr) begin
      if (bus_addr == OFS_PROT) prot_q <= bus_wdata[0];
      if (bus_addr == OFS_TEST) test_q <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (in_vaddr) rd_next = sel_vaddr;
    else if (in_vctrl) rd_next = 32'(sel_vctrl);
    else if (bus_addr[11:4] == OFS_ID_BASE[11:4] && bus_addr[1:0] == 2'b00)
      rd_next = {24'h0, ID_WORD[8*bus_addr[3:2] +: 8]};
    else begin
      case (bus_addr)
        OFS_IRQ_STAT: rd_next = 32'(irq_stat);
        OFS_FIQ_STAT: rd_next = 32'(fiq_stat);
        OFS_RAW:      rd_next = 32'(raw);
        OFS_ROUTE:    rd_next = 32'(route_q);
        OFS_EN_SET:   rd_next = 32'(en_q);
        OFS_SW_SET:   rd_next = 32'(soft_q);
        OFS_PROT:     rd_next = {31'h0, prot_q};
        OFS_VEC_CUR:  rd_next = cur_addr;
        OFS_VEC_DEF:  rd_next = def_q;
        OFS_TEST:     rd_next = {31'h0, test_q};
        default:      rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/vic_checks.sv
module vic_checks #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_wr,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rvalid,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [NSRC-1:0]  irq_stat,
  input logic [NSRC-1:0]  fiq_stat,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  soft_q,
  input logic [NSLOT-1:0] stack_q
);
  logic wr_en_set, wr_en_clr, wr_sw_set, wr_sw_clr, wr_ack;
  assign wr_en_set = bus_en && bus_wr && bus_addr == 12'h010;
  assign wr_en_clr = bus_en && bus_wr && bus_addr == 12'h014;
  assign wr_sw_set = bus_en && bus_wr && bus_addr == 12'h018;
  assign wr_sw_clr = bus_en && bus_wr && bus_addr == 12'h01c;
  assign wr_ack    = bus_en && bus_wr && bus_addr == 12'h030;

  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));
  p_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw_set |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  p_sw_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw_clr |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == '0));
  p_route_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat & fiq_stat) == '0);
  p_irq_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|irq_stat));
  p_fiq_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == $past(|fiq_stat));
  p_ack_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && stack_q != '0) |=> ($countones(stack_q) == $countones($past(stack_q)) - 1));
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr) |=> bus_rvalid);
endmodule

bind vector_irq_ctrl vic_checks #(.NSRC(NSRC), .NSLOT(NSLOT)) u_vic_checks (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .irq_o(irq_o), .fiq_o(fiq_o), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
  .en_q(en_q), .soft_q(soft_q), .stack_q(stack_q)
);

// File: tb/test_vector_irq_ctrl.sv
module test_vector_irq_ctrl;
  localparam logic [31:0] IDW = 32'h0004_1190;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_en, m_sel, m_soft, m_def;
  logic [31:0] m_addr [16];
  logic [5:0]  m_ctrl [16];
  logic [15:0] m_stack;

  always #5 clk = ~clk;

  vector_irq_ctrl #(.NSRC(32), .NSLOT(16), .ID_WORD(IDW)) i_vector_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    case (a)
      12'h00c: m_sel = d;
      12'h010: m_en = m_en | d;
      12'h014: m_en = m_en & ~d;
      12'h018: m_soft = m_soft | d;
      12'h01c: m_soft = m_soft & ~d;
      12'h030: m_stack = m_stack & (m_stack - 16'd1);
      12'h034: m_def = d;
      default: begin
        if (a[11:8] == 4'h1 && a[7:6] == 2'b00) m_addr[a[5:2]] = d;
        if (a[11:8] == 4'h2 && a[7:6] == 2'b00) m_ctrl[a[5:2]] = d[5:0];
      end
    endcase
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    chk("R12 rvalid", {31'h0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  function automatic logic [31:0] m_irq();
    return (src_i | m_soft) & m_en & ~m_sel;
  endfunction

  function automatic logic [31:0] m_fiq();
    return (src_i | m_soft) & m_en & m_sel;
  endfunction

  function automatic int pick();
    int lvl = 16;
    int w = -1;
    logic [31:0] st = m_irq();
    for (int i = 15; i >= 0; i--) if (m_stack[i]) lvl = i;
    for (int i = 15; i >= 0; i--)
      if (i < lvl && m_ctrl[i][5] && st[m_ctrl[i][4:0]]) w = i;
    return w;
  endfunction

  task automatic vec_read(input string req);
    int s = pick();
    logic [31:0] exp = (s >= 0) ? m_addr[s] : m_def;
    rd_chk(req, 12'h030, exp);
    if (s >= 0) m_stack[s] = 1'b1;
  endtask

  task automatic model_reset();
    m_en = '0; m_sel = '0; m_soft = '0; m_def = '0; m_stack = '0;
    for (int i = 0; i < 16; i++) begin m_addr[i] = '0; m_ctrl[i] = '0; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
    chk("R1 fiq_o", {31'h0, fiq_o}, 32'h0);
    rd_chk("R1 enable", 12'h010, 32'h0);
    rd_chk("R1 route", 12'h00c, 32'h0);
    rd_chk("R1 soft", 12'h018, 32'h0);
    rd_chk("R1 vctrl", 12'h23c, 32'h0);
    rd_chk("R1 vaddr", 12'h104, 32'h0);
    rd_chk("R1 prot", 12'h020, 32'h0);
    rd_chk("R1 default vector", 12'h030, 32'h0);

    // R3: write-one semantics, zeros have no effect
    wr(12'h010, 32'h0000_00f0);
    wr(12'h010, 32'h0);
    wr(12'h014, 32'h0);
    rd_chk("R3 zero writes keep enables", 12'h010, 32'h0000_00f0);
    wr(12'h014, 32'h0000_0030);
    rd_chk("R3 clear", 12'h010, 32'h0000_00c0);
    rd_chk("R12 write-only clear reads zero", 12'h014, 32'h0);

    // R2 / R4: soft bits and raw
    src_i = 32'h0001_0000;
    wr(12'h018, 32'h0000_0080);
    rd_chk("R2 raw", 12'h008, 32'h0001_0080);
    rd_chk("R4 soft pending in status", 12'h000, 32'h0000_0080);
    rd_chk("R4 soft stays", 12'h000, 32'h0000_0080);
    wr(12'h01c, 32'h0000_0080);
    rd_chk("R4 soft cleared", 12'h000, 32'h0);

    // R5 / R6: routing and registered outputs
    wr(12'h00c, 32'h0000_0040);
    src_i = 32'h0000_0040;
    #1 chk("R6 fiq_o not yet", {31'h0, fiq_o}, 32'h0);
    @(negedge clk);
    chk("R6 fiq_o after one edge", {31'h0, fiq_o}, 32'h1);
    chk("R6 irq_o idle", {31'h0, irq_o}, 32'h0);
    rd_chk("R5 fiq status", 12'h004, 32'h0000_0040);
    rd_chk("R5 irq status", 12'h000, 32'h0);
    src_i = '0;

    // R10 / R11 / R12
    wr(12'h020, 32'h1);
    rd_chk("R10 prot", 12'h020, 32'h1);
    wr(12'h300, 32'h1);
    rd_chk("R10 test", 12'h300, 32'h1);
    for (int i = 0; i < 4; i++)
      rd_chk("R11 id byte", 12'hfe0 + 12'(4 * i), {24'h0, IDW[8*i +: 8]});
    rd_chk("R12 unmapped", 12'h040, 32'h0);

    // R7 / R8 / R9: nesting
    do_reset();
    wr(12'h010, 32'hffff_ffff);
    wr(12'h034, 32'hdead_0000);
    wr(12'h200, 32'h23); wr(12'h100, 32'ha000_0000);
    wr(12'h204, 32'h27); wr(12'h104, 32'ha000_0001);
    wr(12'h208, 32'h29); wr(12'h108, 32'ha000_0002);
    wr(12'h20c, 32'h0a); wr(12'h10c, 32'ha000_0003);
    src_i = 32'h0000_0680;
    rd_chk("R7 slot 1 wins", 12'h030, 32'ha000_0001); m_stack = 16'h0002;
    rd_chk("R9 lower masked", 12'h030, 32'hdead_0000);
    src_i = 32'h0000_0688;
    rd_chk("R9 higher preempts", 12'h030, 32'ha000_0000); m_stack = 16'h0003;
    wr(12'h030, 32'h0);
    src_i = 32'h0000_0680;
    rd_chk("R8 default while slot 1 in service", 12'h030, 32'hdead_0000);
    wr(12'h030, 32'h0);
    rd_chk("R9 all retired", 12'h030, 32'ha000_0001);
    wr(12'h030, 32'h0);
    wr(12'h030, 32'h0);
    wr(12'h00c, 32'h0000_0080);
    rd_chk("R7 fast-routed source skipped", 12'h030, 32'ha000_0002);
    wr(12'h030, 32'h0);

    // random phase
    do_reset();
    for (int k = 0; k < 600; k++) begin
      int op = int'($urandom_range(0, 10));
      case (op)
        0: wr(12'h010, $urandom);
        1: wr(12'h014, $urandom);
        2: wr(12'h018, $urandom & $urandom & $urandom);
        3: wr(12'h01c, $urandom);
        4: wr(12'h00c, $urandom & $urandom);
        5: begin src_i = $urandom & $urandom & $urandom; @(negedge clk); end
        6: wr(12'h200 + 12'(4 * $urandom_range(0, 15)), {26'h0, 1'($urandom), 5'($urandom)});
        7: wr(12'h100 + 12'(4 * $urandom_range(0, 15)), $urandom);
        8, 9: vec_read("R7 random vector");
        default: wr(12'h030, $urandom);
      endcase
      @(negedge clk);
      chk("R6 irq_o", {31'h0, irq_o}, {31'h0, |m_irq()});
      chk("R6 fiq_o", {31'h0, fiq_o}, {31'h0, |m_fiq()});
      rd_chk("R5 irq status", 12'h000, m_irq());
      if (k % 8 == 0) begin
        rd_chk("R5 fiq status", 12'h004, m_fiq());
        rd_chk("R2 raw", 12'h008, src_i | m_soft);
        rd_chk("R3 enable", 12'h010, m_en);
        rd_chk("R4 soft", 12'h018, m_soft);
      end
    end

    summary();
    $finish;
  end
endmodule